// File: doc/BRIEF.md
# Transmit Descriptor Ownership Pool

This block keeps a small, fixed set of transmit descriptors that host software fills in through a register port, so that packets can be handed to a transmit engine. Each descriptor holds a packet length and a go flag, and is either free (software may write it) or owned by hardware (queued for, or in, transmission). Software may pick any free descriptor in any order. A write that sets the go flag with a non-zero length gives the descriptor to hardware, and its index is appended to a submission-order queue.

The transmit engine sees the oldest owned descriptor as a request carrying its index and length. When the engine reports that the packet is done, the descriptor returns to free with its length kept, and the next oldest one is presented. A per-descriptor free mask and an any-free flag let software see when it must wait for a release. The packet datapath and the buffer memory lie outside this block.

Top module: `tx_desc_pool`

## Requirements
- R1: After reset all descriptors are free (free_mask all ones, any_free high), tx_req is low and every descriptor reads back as zero.
- R2: Descriptor i lives at byte offset 0x20 + 4*i (0x20, 0x24, 0x28, 0x2C for the four default descriptors); a write to any other offset changes nothing, and a read of any other offset returns zero.
- R3: A write to a free descriptor with the go flag (bit 16) set and a non-zero length in bits [10:0] makes it owned on the next cycle: its free_mask bit drops and its readback shows bit 16 set and the length in bits [10:0].
- R4: A write to a free descriptor with bit 16 clear stores the length and leaves the descriptor free and unqueued.
- R5: A write with bit 16 set and a zero length is rejected: the descriptor stays free and its stored length is unchanged.
- R6: Any write to an owned descriptor is ignored; its readback and ownership are unchanged.
- R7: While any descriptor is owned, tx_req is high and tx_idx/tx_len name the owned descriptor that was submitted earliest.
- R8: tx_done while tx_req is high releases the presented descriptor on the next cycle: bit 16 reads zero, the length is kept, its free_mask bit rises, and the next oldest descriptor is presented.
- R9: tx_done while tx_req is low has no effect.
- R10: When every descriptor is owned, any_free is low; it rises again once one is released.
- R11: Readback carries only bits [10:0] and bit 16; write data bits 11 to 15 and 17 to 31 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset within the register area |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the addressed descriptor, combinational |
| free_mask | output | 4 | One bit per descriptor, high when free |
| any_free | output | 1 | High when at least one descriptor is free |
| tx_req | output | 1 | A descriptor is waiting for the transmit engine |
| tx_idx | output | 2 | Index of the presented descriptor |
| tx_len | output | 11 | Length of the presented descriptor |
| tx_done | input | 1 | Engine has finished the presented descriptor |

## Verification
A lost or duplicated entry in the submission queue shows at the engine side on the next completion: the wrong index is presented, or tx_req stays high after the last release, or drops while a descriptor still reads as busy. A descriptor stuck in the owned state shows at once as a cleared free_mask bit that no completion restores, and a missed ownership change shows in the very next readback of bit 16. Ordering faults are exposed by submitting out of index order and resubmitting a released descriptor behind older ones.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // Length field width and position of the go/busy flag in the register word.
  localparam int TXD_LEN_W  = 11;
  localparam int TXD_GO_BIT = 16;
  localparam int TXD_WORD_W = 32;

  typedef logic [TXD_LEN_W-1:0] txd_len_t;

  // Build the readback word from a descriptor's state.
  function automatic logic [TXD_WORD_W-1:0] txd_pack(input logic busy, input txd_len_t len);
    logic [TXD_WORD_W-1:0] w;
    w = '0;
    w[TXD_LEN_W-1:0] = len;
    w[TXD_GO_BIT]    = busy;
    return w;
  endfunction
endpackage

// File: rtl/txd_addr_dec.sv
module txd_addr_dec #(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h20,
  parameter int STRIDE   = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_DESC-1:0] hit
);
  for (genvar i = 0; i < NUM_DESC; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(int'(BASE) + i * STRIDE);
    assign hit[i] = (addr == SLOT_ADDR);
  end
endmodule

// File: rtl/txd_slot.sv
module txd_slot
  import txd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_hit,
  input  logic     go,
  input  txd_len_t len_in,
  input  logic     release_i,
  output logic     busy,
  output txd_len_t len,
  output logic     take
);
  logic     stage;
  logic     busy_d;
  logic     len_en;
  txd_len_t len_d;

  always_comb begin
    take   = wr_hit && !busy && go && (len_in != '0);
    stage  = wr_hit && !busy && !go;
    busy_d = busy;
    if (take)           busy_d = 1'b1;
    else if (release_i) busy_d = 1'b0;
    len_en = take || stage;
    len_d  = len_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      len  <= '0;
    end else begin
      busy <= busy_d;
      if (len_en) len <= len_d;
    end
  end

  a_r6_owned_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && busy && !release_i) |=> (busy && $stable(len)));
  a_r8_release_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> busy);
  a_r5_zero_len_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !busy && go && (len_in == '0)) |=> (!busy && $stable(len)));
  a_r4_stage_stays_free: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !busy && !go) |=> !busy);
endmodule

// File: rtl/txd_order_fifo.sv
module txd_order_fifo #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             not_empty,
  output logic [IDX_W-1:0] head_idx,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (push) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    if (push && !pop)      count_d = count + 1'b1;
    else if (pop && !push) count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // Storage needs no reset: an entry is only read after it was written.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_idx;
  end

  assign not_empty = (count != '0);
  assign head_idx  = mem[rd_ptr];

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((count < CNT_W'(DEPTH)) || pop));
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/tx_desc_pool.sv
module tx_desc_pool
  import txd_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DESC_BASE = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [TXD_WORD_W-1:0] reg_wdata,
  output logic [TXD_WORD_W-1:0] reg_rdata,
  output logic [NUM_DESC-1:0]   free_mask,
  output logic                  any_free,
  output logic                  tx_req,
  output logic [$clog2(NUM_DESC)-1:0] tx_idx,
  output logic [TXD_LEN_W-1:0]  tx_len,
  input  logic                  tx_done
);
  localparam int IDX_W = $clog2(NUM_DESC);
  localparam int CNT_W = $clog2(NUM_DESC+1);

  // Reset: asserted at once, released through two flops.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [NUM_DESC-1:0] hit, busy_vec, take_vec, rel_vec;
  txd_len_t            len_arr [NUM_DESC];
  logic                push, pop, q_ne;
  logic [IDX_W-1:0]    push_idx, head_idx;
  logic [CNT_W-1:0]    q_count;

  txd_addr_dec #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .BASE(DESC_BASE), .STRIDE(4)) u_dec (
    .addr (reg_addr),
    .hit  (hit)
  );

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_slot
    assign rel_vec[i] = pop && (head_idx == IDX_W'(i));
    txd_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_q),
      .wr_hit    (reg_wr && hit[i]),
      .go        (reg_wdata[TXD_GO_BIT]),
      .len_in    (reg_wdata[TXD_LEN_W-1:0]),
      .release_i (rel_vec[i]),
      .busy      (busy_vec[i]),
      .len       (len_arr[i]),
      .take      (take_vec[i])
    );
  end

  // One write per cycle, so at most one take bit is set.
  always_comb begin
    push     = |take_vec;
    push_idx = '0;
    for (int i = 0; i < NUM_DESC; i++)
      if (take_vec[i]) push_idx = IDX_W'(i);
  end

  assign pop = q_ne && tx_done;

  txd_order_fifo #(.DEPTH(NUM_DESC), .IDX_W(IDX_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (push),
    .push_idx  (push_idx),
    .pop       (pop),
    .not_empty (q_ne),
    .head_idx  (head_idx),
    .count     (q_count)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_DESC; i++)
      if (hit[i]) reg_rdata = txd_pack(busy_vec[i], len_arr[i]);
  end

  assign free_mask = ~busy_vec;
  assign any_free  = |free_mask;
  assign tx_req    = q_ne;
  assign tx_idx    = head_idx;
  assign tx_len    = len_arr[head_idx];

  a_r10_queue_matches_owned: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(busy_vec) == int'(q_count));
  a_r7_head_is_owned: assert property (@(posedge clk) disable iff (!rst_q)
    tx_req |-> busy_vec[tx_idx]);
  a_r8_done_frees_head: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_req && tx_done) |=> free_mask[$past(tx_idx)]);
  a_r9_idle_done_no_change: assert property (@(posedge clk) disable iff (!rst_q)
    (!tx_req && tx_done && !reg_wr) |=> $stable(free_mask));
endmodule

// File: tb/tb_tx_desc_pool.sv
module tb_tx_desc_pool;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  free_mask;
  logic        any_free;
  logic        tx_req;
  logic [1:0]  tx_idx;
  logic [10:0] tx_len;
  logic        tx_done;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  tx_desc_pool dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .free_mask(free_mask),
    .any_free(any_free), .tx_req(tx_req), .tx_idx(tx_idx), .tx_len(tx_len),
    .tx_done(tx_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive a write on a falling edge; returns on the falling edge after the capture.
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 free_mask", 32'(free_mask), 32'hF);
    chk("R1 any_free", 32'(any_free), 32'h1);
    chk("R1 tx_req", 32'(tx_req), 32'h0);
    for (int i = 0; i < 4; i++) rd_chk("R1 readback", 8'(8'h20 + 4*i), 32'h0);
  endtask

  task automatic t_stage();
    // Go clear, junk in bits 11-15 and 17-31: only length 0x155 is kept.
    wr_reg(8'h24, 32'hFFFE_F955);
    rd_chk("R4 R11 staged length", 8'h24, 32'h0000_0155);
    chk("R4 stays free", 32'(free_mask), 32'hF);
    chk("R4 not queued", 32'(tx_req), 32'h0);
  endtask

  task automatic t_map();
    wr_reg(8'h30, 32'h0001_0005);
    chk("R2 unmapped write", 32'(free_mask), 32'hF);
    rd_chk("R2 unmapped read", 8'h30, 32'h0);
    rd_chk("R2 misaligned read", 8'h26, 32'h0);
  endtask

  task automatic t_zero();
    wr_reg(8'h24, 32'h0001_0000);
    chk("R5 zero length stays free", 32'(free_mask), 32'hF);
    rd_chk("R5 length kept", 8'h24, 32'h0000_0155);
  endtask

  task automatic t_idle_done();
    done_pulse();
    chk("R9 idle done free_mask", 32'(free_mask), 32'hF);
    chk("R9 idle done tx_req", 32'(tx_req), 32'h0);
  endtask

  task automatic t_fill_and_order();
    wr_reg(8'h28, 32'h0001_0064);  // slot 2, len 100
    chk("R3 slot2 owned", 32'(free_mask), 32'hB);
    chk("R7 first request", {tx_req, 29'd0, tx_idx}, {1'b1, 29'd0, 2'd2});
    wr_reg(8'h20, 32'h0001_00C8);  // slot 0, len 200
    wr_reg(8'h2C, 32'h0001_012C);  // slot 3, len 300
    chk("R10 one left", 32'(any_free), 32'h1);
    wr_reg(8'h24, 32'h0001_0190);  // slot 1, len 400
    chk("R10 all owned", 32'(any_free), 32'h0);
    chk("R10 free_mask empty", 32'(free_mask), 32'h0);
    rd_chk("R3 readback busy", 8'h20, 32'h0001_00C8);
    chk("R7 oldest idx", 32'(tx_idx), 32'd2);
    chk("R7 oldest len", 32'(tx_len), 32'd100);
    wr_reg(8'h20, 32'h0001_0007);
    rd_chk("R6 go write to owned", 8'h20, 32'h0001_00C8);
    wr_reg(8'h20, 32'h0000_0009);
    rd_chk("R6 stage write to owned", 8'h20, 32'h0001_00C8);
  endtask

  task automatic t_release();
    done_pulse();
    rd_chk("R8 released keeps length", 8'h28, 32'h0000_0064);
    chk("R8 free_mask", 32'(free_mask), 32'h4);
    chk("R10 any_free back", 32'(any_free), 32'h1);
    chk("R8 next idx", 32'(tx_idx), 32'd0);
    chk("R8 next len", 32'(tx_len), 32'd200);
    // Resubmit slot 2 behind the older ones.
    wr_reg(8'h28, 32'h0001_0032);
    chk("R3 resubmit owned", 32'(free_mask), 32'h0);
    done_pulse();
    chk("R7 order idx 3", {tx_req, 29'd0, tx_idx}, {1'b1, 29'd0, 2'd3});
    chk("R7 order len 300", 32'(tx_len), 32'd300);
    done_pulse();
    chk("R7 order idx 1", 32'(tx_idx), 32'd1);
    done_pulse();
    chk("R7 order idx 2", 32'(tx_idx), 32'd2);
    chk("R7 resubmit len", 32'(tx_len), 32'd50);
    done_pulse();
    chk("R8 queue drained", 32'(tx_req), 32'h0);
    chk("R8 all free", 32'(free_mask), 32'hF);
    rd_chk("R8 slot1 length kept", 8'h24, 32'h0000_0190);
  endtask

  initial begin
    #800000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; tx_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stage();
    t_map();
    t_zero();
    t_idle_done();
    t_fill_and_order();
    t_release();
    t_idle_done();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule